// File: doc/BRIEF.md
# Eight-Line GPIO Controller with Interrupt Detection

A memory-mapped general-purpose I/O peripheral for eight pins, reached over a simple register bus: a select, a write strobe, a 12-bit byte address and 8-bit data. Software sets each pin's direction, drives output values and samples inputs through a data window. In that window, address bits [9:2] act as a per-pin mask, so one access can touch any subset of pins without a read-modify-write.

Each input is synchronised by two flops and then feeds an interrupt detector. The detector can sense a high or low level, a rising or falling edge, or both edges. Edge events are latched in a raw status register and are cleared by writing ones. Level events are not latched: they follow the pin. An enable mask gates the raw status into a masked status, and the single interrupt output is the OR of the masked bits.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset every register reads 0. `pin_oe`, `pin_out` and `irq` are 0, so all pins are inputs with interrupts disabled.
- R2: The direction register at 0x400 drives `pin_oe` one clock after the write. A bit of 1 makes that pin an output, and `pin_out` shows the driven value of output pins.
- R3: A write with `addr[11:10]`=0 updates only pins n whose mask bit `addr[n+2]` is 1. Other output values are kept.
- R4: A read with `addr[11:10]`=0 returns 0 for pins whose mask bit is 0. A masked output pin returns its driven value. A masked input pin returns its input as sampled two clocks earlier.
- R5: A data write to a pin while it is an input has no effect. Setting that pin to output later drives the value it held before.
- R6: With its bit in the sense register (0x404) set to 1, a pin's raw status (0x414) is 1 exactly while its synchronised input equals its polarity bit (0x40C). The bit is not latched and ignores clear writes.
- R7: With sense 0 and both-edges (0x408) 0, a polarity bit of 1 latches raw status on a rising edge and 0 latches on a falling edge. The opposite edge does not set it.
- R8: With sense 0 and both-edges 1, either edge latches raw status whatever the polarity bit holds.
- R9: Masked status (0x418) equals raw status AND the enable register (0x410), and `irq` is 1 exactly when any masked bit is 1.
- R10: Writing to the clear register (0x41C) clears latched edge bits whose data bit is 1 and leaves the others.
- R11: An edge detected in the same clock as a clear write to that bit leaves the bit set.
- R12: Configuration registers read back the value written. Offsets above 0x41C, offsets that are not word aligned, and reads without select return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus select |
| wr | input | 1 | Write strobe; the write takes effect at the clock edge while sel is high |
| addr | input | 12 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr while sel is high |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge that is detected in the same clock as a clear write to its bit. The pin change has to pass three flops before the detector fires, so the bench changes the pin on a falling clock edge and waits two more falling edges. It then issues the clear so that the clear lands on the rising edge where the detector fires. The bench expects the status bit to stay set. A second clear that arrives alone must then remove the bit.

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr,
  input  logic [11:0]  addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         irq
);
  logic [N-1:0] dout, dir, sense, both, pol, ie, lat, s1, s2, s3;
  logic [N-1:0] rise, fall, hit, level, raw, clr, pins;

  wire       aligned  = addr[1:0] == 2'b00;
  wire [9:0] wa       = addr[11:2];
  wire       data_win = addr[11:10] == 2'b00;
  wire       wr_en    = sel & wr & aligned;
  wire [N-1:0] mask   = addr[N+1:2];

  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
  assign hit   = ~sense & ((both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall));
  assign level = sense & ~(s2 ^ pol);
  assign raw   = (~sense & lat) | level;
  assign clr   = (wr_en && wa == 10'h107) ? wdata : '0;
  assign pins  = (dir & dout) | (~dir & s2);

  assign pin_out = dout;
  assign pin_oe  = dir;
  assign irq     = |(raw & ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      lat <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      lat <= (lat & ~clr) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      dir   <= '0;
      sense <= '0;
      both  <= '0;
      pol   <= '0;
      ie    <= '0;
    end else if (wr_en) begin
      if (data_win)
        dout <= (dout & ~(mask & dir)) | (wdata & mask & dir);
      else
        case (wa)
          10'h100: dir   <= wdata;
          10'h101: sense <= wdata;
          10'h102: both  <= wdata;
          10'h103: pol   <= wdata;
          10'h104: ie    <= wdata;
          default: ;
        endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr && aligned) begin
      if (data_win)
        rdata = pins & mask;
      else
        case (wa)
          10'h100: rdata = dir;
          10'h101: rdata = sense;
          10'h102: rdata = both;
          10'h103: rdata = pol;
          10'h104: rdata = ie;
          10'h105: rdata = raw;
          10'h106: rdata = raw & ie;
          default: rdata = '0;
        endcase
    end
  end
endmodule

module gpio8_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel,
  input logic         wr,
  input logic [11:0]  addr,
  input logic [N-1:0] wdata,
  input logic [N-1:0] rdata,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe
);
  wire data_wr = sel && wr && addr[11:10] == 2'b00 && addr[1:0] == 2'b00;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 12'h400) |=> pin_oe == $past(wdata));

  p_masked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((pin_out ^ $past(pin_out)) & ~$past(addr[N+1:2])) == '0);

  p_input_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  p_no_write_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(pin_out));

  p_undefined_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || addr > 12'h41C || addr[1:0] != 2'b00) |-> rdata == '0);
endmodule

bind gpio8_ctrl gpio8_ctrl_chk #(.N(N)) u_chk (.*);

// File: tb/sim_gpio8_ctrl.sv
`timescale 1ns/1ps
module sim_gpio8_ctrl;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, pin_in = '0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio8_ctrl u0 (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    bus_rd(12'h400, v); chk("R1 dir", v, 8'h00);
    bus_rd(12'h410, v); chk("R1 enable", v, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] v;
    pin_in = 8'h30;
    bus_wr(12'h400, 8'h0F);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    bus_wr(12'h3FC, 8'hA5);
    chk("R2 pin_out", pin_out, 8'h05);
    bus_wr(12'h00C, 8'hFF);
    chk("R3 masked write", pin_out, 8'h07);
    settle();
    bus_rd(12'h3FC, v); chk("R4 full read", v, 8'h37);
    bus_rd(12'h044, v); chk("R4 masked read", v, 8'h11);
    bus_wr(12'h3FC, 8'hF0);
    bus_wr(12'h400, 8'hFF);
    chk("R5 input write ignored", pin_out, 8'h00);
    bus_wr(12'h3FC, 8'hC3);
    chk("R2 output drive", pin_out, 8'hC3);
    bus_wr(12'h400, 8'h00);
    pin_in = 8'h00;
    settle();
    bus_wr(12'h41C, 8'hFF);
  endtask

  task automatic t_level();
    logic [7:0] v;
    bus_wr(12'h404, 8'h01);
    bus_wr(12'h40C, 8'h01);
    bus_wr(12'h410, 8'h01);
    bus_rd(12'h414, v); chk("R6 level idle", v, 8'h00);
    pin_in = 8'h01; settle();
    bus_rd(12'h414, v); chk("R6 high level", v, 8'h01);
    bus_rd(12'h418, v); chk("R9 masked", v, 8'h01);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    bus_wr(12'h41C, 8'h01);
    bus_rd(12'h414, v); chk("R6 clear ignored", v, 8'h01);
    pin_in = 8'h00; settle();
    bus_rd(12'h414, v); chk("R6 level gone", v, 8'h00);
    chk("R9 irq low", {7'd0, irq}, 8'h00);
    bus_wr(12'h40C, 8'h00);
    bus_rd(12'h414, v); chk("R6 low level", v, 8'h01);
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h410, 8'h00);
    bus_rd(12'h414, v); chk("R6 back to edge", v, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    bus_wr(12'h40C, 8'h02);
    bus_wr(12'h410, 8'h02);
    bus_wr(12'h41C, 8'hFF);
    pin_in = 8'h04; settle();
    bus_rd(12'h414, v); chk("R7 wrong edge", v, 8'h00);
    pin_in = 8'h02; settle();
    bus_rd(12'h414, v); chk("R7 edges latched", v, 8'h06);
    bus_rd(12'h418, v); chk("R9 masked edge", v, 8'h02);
    chk("R9 irq edge", {7'd0, irq}, 8'h01);
    pin_in = 8'h00; settle();
    bus_rd(12'h414, v); chk("R7 held", v, 8'h06);
    bus_wr(12'h41C, 8'h02);
    bus_rd(12'h414, v); chk("R10 partial clear", v, 8'h04);
    chk("R10 irq cleared", {7'd0, irq}, 8'h00);
    bus_wr(12'h41C, 8'h04);
    bus_rd(12'h414, v); chk("R10 clear rest", v, 8'h00);
    bus_wr(12'h40C, 8'h00);
    bus_wr(12'h410, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] v;
    bus_wr(12'h408, 8'h01);
    pin_in = 8'h01; settle();
    bus_rd(12'h414, v); chk("R8 rise with pol 0", v, 8'h01);
    bus_wr(12'h41C, 8'h01);
    bus_rd(12'h414, v); chk("R10 cleared", v, 8'h00);
    pin_in = 8'h00;
    @(negedge clk);
    @(negedge clk);
    bus_wr(12'h41C, 8'h01);
    bus_rd(12'h414, v); chk("R11 edge beats clear", v, 8'h01);
    bus_wr(12'h41C, 8'h01);
    bus_rd(12'h414, v); chk("R10 clear after", v, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] v;
    bus_rd(12'h408, v); chk("R12 readback", v, 8'h01);
    bus_wr(12'h404, 8'h5A);
    bus_rd(12'h404, v); chk("R12 sense readback", v, 8'h5A);
    bus_rd(12'h420, v); chk("R12 undefined", v, 8'h00);
    bus_rd(12'hFFC, v); chk("R12 top offset", v, 8'h00);
    bus_rd(12'h405, v); chk("R12 misaligned", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_level();
    t_edge();
    t_both();
    t_map();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule